// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block stores a stream of 32-bit trace words in an on-chip RAM that is used as a ring. Capture runs after software sets the enable bit. Each word offered on the valid/data input goes to the write pointer, which then steps forward and wraps. A sticky flag shows that the ring has been filled at least once. A trigger input starts a programmable count of further words, and when that count runs out capture can stop. This keeps a window of history around the trigger event.

Software reaches the buffer through a simple register port that has separate read and write strobes. Read data is combinational on the same cycle. The port gives access to the depth, the status flag, both pointers, the post-trigger count, the enable, a data window for each direction, and a flush control/status pair. A read of the read-data window and a write to the write-data window each advance their pointer. This lets software dump or preload the RAM with no other address arithmetic. Stored trace is grouped in frames of four words. Whenever capture stops, or a manual flush runs, the block pads the open frame with zero words so that the write pointer ends on a frame boundary.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the depth register (offset 0x004) reads DEPTH with bit 31 at 0. Status, both pointers, the control register and flush control all read 0. Flush status (offset 0x300) reads 2, because bit 1 reports that capture is stopped.
- R2: A register write to control (0x020) with bit 0 set starts capture. While capture runs, each cycle with trc_valid high stores trc_data at the write pointer (0x018), and the pointer then increments and wraps from DEPTH-1 to 0.
- R3: Status bit 0 (0x00C) sets when the write pointer wraps, whether capture or a software data write caused the wrap. A software write to the write-pointer register clears it.
- R4: A read of 0x010 returns the RAM word at the read pointer (0x014), and the read pointer then increments modulo DEPTH. A write to 0x014 loads the read pointer.
- R5: While capture is stopped, a write to 0x024 stores the value at the write pointer and increments the pointer, and a write to 0x018 loads the pointer. While capture is not stopped, both writes are ignored.
- R6: When flush-control (0x304) bit 13 is set, a trigger pulse loads the count from 0x01C. Exactly that many further valid words are stored, and capture then stops. Words offered after that are dropped.
- R7: When flush-control bit 13 is clear, a trigger does not stop capture.
- R8: Whenever capture stops, zero words are written until the write pointer is a multiple of 4. Flush status bit 1 then reads 1.
- R9: Writing 0 to control bit 0 while capture runs stops capture, and the padding of R8 applies.
- R10: Writing 1 to flush-control bit 6 starts a flush. Bit 6 reads 1 while the flush is in progress. Input words are dropped, the open frame is padded with zeros, and the bit then clears by itself. Flush-control bits 0, 12 and 13 read back as written. If bit 12 is set, capture stops when the flush completes. Otherwise capture continues.
- R11: Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_valid | input | 1 | Trace word present this cycle |
| trc_data | input | 32 | Trace word |
| trc_trig | input | 1 | Trigger event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances read pointer on 0x010) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
Capture is driven with bursts that include idle gaps. This separates storing on valid from storing on every cycle. A burst starting at offset 60 shows whether the pointer wraps and the full flag rises at the right edge. A trigger run with a count of 5, with extra words offered afterwards, tells an off-by-one in the stop count from a correct stop. The same trigger with the stop bit clear shows that the trigger alone does not halt capture. Bursts that end mid-frame, stopped in turn by disable, by trigger expiry and by flush, show that the zero padding lands only on the open frame. Readback past the pad shows that older RAM contents are left untouched.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
   localparam logic [11:0] OFF_DEPTH = 12'h004;
   localparam logic [11:0] OFF_STAT  = 12'h00C;
   localparam logic [11:0] OFF_RDAT  = 12'h010;
   localparam logic [11:0] OFF_RPTR  = 12'h014;
   localparam logic [11:0] OFF_WPTR  = 12'h018;
   localparam logic [11:0] OFF_TRG   = 12'h01C;
   localparam logic [11:0] OFF_CTL   = 12'h020;
   localparam logic [11:0] OFF_WDAT  = 12'h024;
   localparam logic [11:0] OFF_FSTAT = 12'h300;
   localparam logic [11:0] OFF_FCTL  = 12'h304;

   localparam int FC_FMT     = 0;
   localparam int FC_FLUSH   = 6;
   localparam int FC_STOP_FL = 12;
   localparam int FC_STOP_TG = 13;

   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_RUN   = 2'd1,
      CAP_DRAIN = 2'd2
   } cap_state_e;
endpackage

// File: rtl/tcb_ptr.sv
module tcb_ptr #(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_i,
   input  logic [31:0]   ld_val_i,
   input  logic          inc_i,
   output logic [AW-1:0] ptr_o,
   output logic          wrap_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] ptr_q, nxt;

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign nxt = ptr_q + 1'b1;
      end else begin : g_cmp
         assign nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ptr_q <= '0;
      else if (ld_i)         ptr_q <= (ld_val_i < 32'(DEPTH)) ? ld_val_i[AW-1:0] : '0;
      else if (inc_i)        ptr_q <= nxt;
   end

   assign ptr_o  = ptr_q;
   assign wrap_o = inc_i && !ld_i && (ptr_q == LAST);

   // R2
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < DEPTH);
endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
   parameter int DEPTH = 64,
   parameter int DW    = 32,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
   import tcb_pkg::*;
#(
   parameter int DW = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          en_i,
   input  logic          stop_tg_i,
   input  logic          stop_fl_i,
   input  logic          flush_set_i,
   input  logic [CW-1:0] trg_load_i,
   input  logic          aligned_i,
   input  logic          tv_i,
   input  logic [DW-1:0] td_i,
   input  logic          trig_i,
   output logic          we_o,
   output logic [DW-1:0] wd_o,
   output logic          idle_o,
   output logic          flush_busy_o
);
   cap_state_e    st_q, st_d;
   logic          seen_q, seen_d, flush_q, flush_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d    = st_q;
      seen_d  = seen_q;
      cnt_d   = cnt_q;
      flush_d = flush_q | flush_set_i;
      we_o    = 1'b0;
      wd_o    = '0;
      unique case (st_q)
         CAP_IDLE: begin
            flush_d = flush_set_i;
            if (start_i) begin
               st_d   = CAP_RUN;
               seen_d = 1'b0;
               cnt_d  = '0;
            end
         end
         CAP_RUN: begin
            if (!en_i) begin
               st_d = CAP_DRAIN;
            end else if (flush_q) begin
               if (aligned_i) begin
                  flush_d = flush_set_i;
                  if (stop_fl_i) st_d = CAP_IDLE;
               end else begin
                  we_o = 1'b1;
               end
            end else if (seen_q && cnt_q == '0 && stop_tg_i) begin
               st_d = CAP_DRAIN;
            end else begin
               if (tv_i) begin
                  we_o = 1'b1;
                  wd_o = td_i;
                  if (seen_q && cnt_q != '0) cnt_d = cnt_q - 1'b1;
               end
               if (trig_i && !seen_q) begin
                  seen_d = 1'b1;
                  cnt_d  = trg_load_i;
               end
            end
         end
         CAP_DRAIN: begin
            if (aligned_i) st_d = CAP_IDLE;
            else           we_o = 1'b1;
         end
         default: st_d = CAP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CAP_IDLE;
         seen_q  <= 1'b0;
         cnt_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         seen_q  <= seen_d;
         cnt_q   <= cnt_d;
         flush_q <= flush_d;
      end
   end

   assign idle_o       = (st_q == CAP_IDLE);
   assign flush_busy_o = flush_q;

   // R8
   stop_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CAP_IDLE && $past(st_q) != CAP_IDLE) |-> aligned_i);

   // R10
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flush_q) |-> ($past(aligned_i) || $past(st_q) != CAP_RUN));

   // R6
   trig_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CAP_RUN && $past(st_q) == CAP_RUN && seen_q && $past(seen_q))
         |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
   import tcb_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int FRAME_WORDS = 4,
   parameter int DW          = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trc_valid,
   input  logic [31:0] trc_data,
   input  logic        trc_trig,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [11:0] reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata
);
   localparam int AW = $clog2(DEPTH);
   localparam int FB = $clog2(FRAME_WORDS);

   generate
      if (DW != 32) begin : g_bad_dw
         $error("trace_capture_buf: DW must be 32");
      end
      if (FRAME_WORDS < 2 || (1 << FB) != FRAME_WORDS) begin : g_bad_frame
         $error("trace_capture_buf: FRAME_WORDS must be a power of two >= 2");
      end
      if (DEPTH % FRAME_WORDS != 0 || DEPTH < FRAME_WORDS) begin : g_bad_depth
         $error("trace_capture_buf: DEPTH must be a multiple of FRAME_WORDS");
      end
   endgenerate

   logic          ctl_en_q, fc_fmt_q, fc_stop_fl_q, fc_stop_tg_q, full_q;
   logic [31:0]   trg_q;
   logic [AW-1:0] wp, rp;
   logic          wp_wrap, rp_wrap_unused;
   logic          hw_we, idle, flush_busy;
   logic [DW-1:0] hw_wd, ram_rd;

   wire wr_ctl  = reg_wr && reg_addr == OFF_CTL;
   wire wr_fctl = reg_wr && reg_addr == OFF_FCTL;
   wire sw_dwe  = reg_wr && reg_addr == OFF_WDAT && idle;
   wire sw_wld  = reg_wr && reg_addr == OFF_WPTR && idle;
   wire rp_ld   = reg_wr && reg_addr == OFF_RPTR;
   wire rp_inc  = reg_rd && reg_addr == OFF_RDAT;
   wire start   = wr_ctl && reg_wdata[0] && idle;
   wire aligned = (wp[FB-1:0] == '0);
   wire ram_we  = hw_we | sw_dwe;
   wire [DW-1:0] ram_wd = hw_we ? hw_wd : reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en_q     <= 1'b0;
         trg_q        <= '0;
         fc_fmt_q     <= 1'b0;
         fc_stop_fl_q <= 1'b0;
         fc_stop_tg_q <= 1'b0;
         full_q       <= 1'b0;
      end else begin
         if (wr_ctl) ctl_en_q <= reg_wdata[0];
         if (reg_wr && reg_addr == OFF_TRG) trg_q <= reg_wdata;
         if (wr_fctl) begin
            fc_fmt_q     <= reg_wdata[FC_FMT];
            fc_stop_fl_q <= reg_wdata[FC_STOP_FL];
            fc_stop_tg_q <= reg_wdata[FC_STOP_TG];
         end
         if (sw_wld)       full_q <= 1'b0;
         else if (wp_wrap) full_q <= 1'b1;
      end
   end

   tcb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
      .clk(clk), .rst_n(rst_n), .ld_i(sw_wld), .ld_val_i(reg_wdata),
      .inc_i(ram_we), .ptr_o(wp), .wrap_o(wp_wrap));

   tcb_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
      .clk(clk), .rst_n(rst_n), .ld_i(rp_ld), .ld_val_i(reg_wdata),
      .inc_i(rp_inc), .ptr_o(rp), .wrap_o(rp_wrap_unused));

   tcb_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
      .clk(clk), .we_i(ram_we), .waddr_i(wp), .wdata_i(ram_wd),
      .raddr_i(rp), .rdata_o(ram_rd));

   tcb_ctrl #(.DW(DW), .CW(32)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start), .en_i(ctl_en_q),
      .stop_tg_i(fc_stop_tg_q), .stop_fl_i(fc_stop_fl_q),
      .flush_set_i(wr_fctl && reg_wdata[FC_FLUSH]), .trg_load_i(trg_q),
      .aligned_i(aligned), .tv_i(trc_valid), .td_i(trc_data), .trig_i(trc_trig),
      .we_o(hw_we), .wd_o(hw_wd), .idle_o(idle), .flush_busy_o(flush_busy));

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFF_DEPTH: reg_rdata = {1'b0, 31'(DEPTH)};
         OFF_STAT:  reg_rdata = {31'b0, full_q};
         OFF_RDAT:  reg_rdata = ram_rd;
         OFF_RPTR:  reg_rdata = 32'(rp);
         OFF_WPTR:  reg_rdata = 32'(wp);
         OFF_TRG:   reg_rdata = trg_q;
         OFF_CTL:   reg_rdata = {31'b0, ctl_en_q};
         OFF_FSTAT: reg_rdata = {30'b0, idle, 1'b0};
         OFF_FCTL: begin
            reg_rdata[FC_FMT]     = fc_fmt_q;
            reg_rdata[FC_FLUSH]   = flush_busy;
            reg_rdata[FC_STOP_FL] = fc_stop_fl_q;
            reg_rdata[FC_STOP_TG] = fc_stop_tg_q;
         end
         default:   reg_rdata = '0;
      endcase
   end

   // R3
   full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> (wp == '0));
endmodule

// File: tb/trace_capture_buf_bench.sv
module trace_capture_buf_bench;
   import tcb_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trc_valid = 1'b0, trc_trig = 1'b0;
   logic [31:0] trc_data = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;

   int checks = 0, errors = 0;
   logic [31:0] exp_q [$];

   always #10 clk = ~clk;

   trace_capture_buf u_trace_capture_buf (
      .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_data(trc_data),
      .trc_trig(trc_trig), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   // driver: offers one trace word, pushes it when it is expected to be kept
   task automatic push(input logic [31:0] d, input logic trig, input logic keep);
      trc_valid = 1'b1; trc_data = d; trc_trig = trig;
      if (keep) exp_q.push_back(d);
      @(negedge clk);
      trc_valid = 1'b0; trc_trig = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: reads the RAM window and pops the scoreboard
   task automatic readout(input int start, input int n, input string req);
      logic [31:0] v;
      wr(OFF_RPTR, 32'(start));
      for (int i = 0; i < n; i++) begin
         rd(OFF_RDAT, v);
         if (exp_q.size() == 0) check({req, " queue empty"}, v, 32'hFFFF_FFFF);
         else check(req, v, exp_q.pop_front());
      end
   endtask

   task automatic wait_stop(input string req);
      logic [31:0] v;
      for (int i = 0; i < 30; i++) begin
         rd(OFF_FSTAT, v);
         if (v[1]) break;
      end
      check(req, v, 32'h2);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", 20000, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      idle(2);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset view, R11 unmapped offset
      rd_chk(OFF_DEPTH, 32'd64, "R1 depth");
      rd_chk(OFF_STAT,  32'h0,  "R1 status");
      rd_chk(OFF_WPTR,  32'h0,  "R1 wptr");
      rd_chk(OFF_RPTR,  32'h0,  "R1 rptr");
      rd_chk(OFF_CTL,   32'h0,  "R1 ctl");
      rd_chk(OFF_FCTL,  32'h0,  "R1 fctl");
      rd_chk(OFF_FSTAT, 32'h2,  "R1 fstat");
      rd_chk(12'h008,   32'h0,  "R11 unmapped");

      // R5 software preload while stopped, R4 read window
      for (int i = 0; i < 4; i++) begin
         wr(OFF_WDAT, 32'hA0 + 32'(i));
         exp_q.push_back(32'hA0 + 32'(i));
      end
      rd_chk(OFF_WPTR, 32'd4, "R5 wptr after sw writes");
      readout(0, 4, "R4 readback");
      rd_chk(OFF_RPTR, 32'd4, "R4 rptr advance");

      // R3 full flag via software wrap, cleared by pointer write
      wr(OFF_WPTR, 0);
      for (int i = 0; i < 64; i++) wr(OFF_WDAT, 32'h5000 + 32'(i));
      rd_chk(OFF_STAT, 32'h1, "R3 full on sw wrap");
      rd_chk(OFF_WPTR, 32'h0, "R3 wptr wrapped");
      wr(OFF_WPTR, 0);
      rd_chk(OFF_STAT, 32'h0, "R3 full cleared");

      // R2 capture with gaps, R5 ignore while running, R9 disable, R8 pad
      wr(OFF_FCTL, 0);
      wr(OFF_CTL, 1);
      for (int i = 0; i < 10; i++) begin
         push(32'hC000_0000 + 32'(i), 1'b0, 1'b1);
         if (i == 2 || i == 6) idle(2);
      end
      rd_chk(OFF_FSTAT, 32'h0, "R9 running");
      rd_chk(OFF_WPTR, 32'd10, "R2 wptr count");
      wr(OFF_WDAT, 32'hDEAD);
      wr(OFF_WPTR, 32'h20);
      rd_chk(OFF_WPTR, 32'd10, "R5 ignored while running");
      wr(OFF_CTL, 0);
      wait_stop("R9 stopped");
      rd_chk(OFF_WPTR, 32'd12, "R8 padded wptr");
      exp_q.push_back(0); exp_q.push_back(0); exp_q.push_back(32'h500C);
      readout(0, 13, "R2 R8 contents");

      // R6 trigger stop after 5 words
      wr(OFF_WPTR, 0);
      wr(OFF_TRG, 5);
      wr(OFF_FCTL, 32'h2001);
      wr(OFF_CTL, 1);
      for (int i = 0; i < 3; i++) push(32'hB000 + 32'(i), 1'b0, 1'b1);
      push(32'hB0FF, 1'b1, 1'b1);
      for (int i = 0; i < 5; i++) push(32'hB100 + 32'(i), 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) push(32'hBE00 + 32'(i), 1'b0, 1'b0);
      wait_stop("R6 stopped after count");
      rd_chk(OFF_WPTR, 32'd12, "R6 wptr");
      for (int i = 0; i < 3; i++) exp_q.push_back(0);
      exp_q.push_back(32'h500C);
      readout(0, 13, "R6 contents");

      // R7 trigger without stop, R10 flush without and with stop
      wr(OFF_WPTR, 0);
      wr(OFF_FCTL, 32'h0001);
      wr(OFF_CTL, 1);
      push(32'hE000, 1'b0, 1'b1);
      push(32'hE001, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) push(32'hE100 + 32'(i), 1'b0, 1'b1);
      idle(3);
      rd_chk(OFF_FSTAT, 32'h0, "R7 still running");
      rd_chk(OFF_WPTR, 32'd8, "R7 wptr");
      push(32'hE200, 1'b0, 1'b1);
      wr(OFF_FCTL, 32'h0041);
      rd_chk(OFF_FCTL, 32'h0041, "R10 busy bit");
      for (int i = 0; i < 20; i++) begin
         rd(OFF_FCTL, v);
         if (!v[6]) break;
      end
      check("R10 self clear", v, 32'h0001);
      rd_chk(OFF_WPTR, 32'd12, "R10 flush pad");
      rd_chk(OFF_FSTAT, 32'h0, "R10 runs on");
      for (int i = 0; i < 3; i++) exp_q.push_back(0);
      push(32'hE300, 1'b0, 1'b1);
      push(32'hE301, 1'b0, 1'b1);
      wr(OFF_FCTL, 32'h1041);
      wait_stop("R10 stop on flush");
      rd_chk(OFF_WPTR, 32'd16, "R10 final wptr");
      rd_chk(OFF_FCTL, 32'h1001, "R10 fctl readback");
      exp_q.push_back(0); exp_q.push_back(0);
      readout(0, 16, "R10 contents");

      // R2 R3 wrap during capture, R4 read pointer wrap
      wr(OFF_FCTL, 0);
      wr(OFF_WPTR, 60);
      wr(OFF_CTL, 1);
      for (int i = 0; i < 6; i++) push(32'hF000 + 32'(i), 1'b0, 1'b1);
      rd_chk(OFF_WPTR, 32'd2, "R2 wrap");
      rd_chk(OFF_STAT, 32'h1, "R3 full on capture wrap");
      wr(OFF_CTL, 0);
      wait_stop("R8 stopped after wrap");
      rd_chk(OFF_WPTR, 32'd4, "R8 pad after wrap");
      exp_q.push_back(0); exp_q.push_back(0);
      readout(60, 8, "R2 wrapped contents");
      rd_chk(OFF_RPTR, 32'd4, "R4 rptr wrap");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule